// File: doc/BRIEF.md
# Conditional Branch Resolver

This block resolves a relative conditional branch for a processor with 16-bit data words and 10-bit opcodes. The pipeline presents the opcode, the displacement word that followed it in memory, the program counter, and the four status flags (carry, overflow, sign, zero). The program counter must already point past the displacement word. The block then decides whether the branch is taken. It also produces the next program counter and the number of machine cycles the instruction costs.

A branch may go forward or backward. A backward branch adds the bitwise complement of the displacement, which equals the negated displacement minus one. The upper half of the sixteen condition codes are the exact negations of the lower half. Branches that test an external condition input are not resolved. They are reported as unsupported, not taken, and charged the not-taken cost. The results are registered and appear one clock after a single-cycle start strobe, together with a one-cycle done pulse. They hold their value until the next start.

Top module: `brcond_unit`

## Requirements
- R1: While reset is asserted and after it is released, before any start, `done_o`, `taken_o` and `unsupported_o` are 0, `next_pc_o` is 0 and `cycles_o` is 0.
- R2: `done_o` is high for exactly one clock, at the rising edge that follows a clock in which `start_i` was high, and is low otherwise.
- R3: The condition is `opcode_i[3:0]`. Codes 0..7 are taken when: 0 always; 1 carry=1; 2 overflow=1; 3 sign=0; 4 zero=1; 5 sign≠overflow; 6 zero=1 or sign≠overflow; 7 carry≠sign.
- R4: Codes 8..15 are taken exactly when code−8 would not be. Code 8 is never taken, whatever the flags.
- R5: When `opcode_i[5]`=0 and the branch is taken, `next_pc_o` = (`pc_i` + `offset_i`) mod 65536.
- R6: When `opcode_i[5]`=1 and the branch is taken, `next_pc_o` = (`pc_i` − `offset_i` − 1) mod 65536, i.e. `pc_i` plus the bitwise complement of `offset_i`.
- R7: When the branch is not taken, `next_pc_o` equals the `pc_i` presented with the start strobe.
- R8: `cycles_o` is 9 for a taken branch and 7 for a not-taken branch.
- R9: When `opcode_i[4]`=1, `unsupported_o`=1, `taken_o`=0, `next_pc_o`=`pc_i` and `cycles_o`=7, regardless of condition and flags. Otherwise `unsupported_o`=0.
- R10: While `start_i` is low, all result outputs (`taken_o`, `unsupported_o`, `next_pc_o`, `cycles_o`) keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle request to resolve the presented branch |
| opcode_i | input | 10 | Branch opcode: [3:0] condition, [4] external-condition marker, [5] backward direction |
| offset_i | input | 16 | Displacement word that followed the opcode |
| pc_i | input | 16 | Program counter, already advanced past the displacement word |
| flag_c_i | input | 1 | Carry flag |
| flag_o_i | input | 1 | Overflow flag |
| flag_s_i | input | 1 | Sign flag |
| flag_z_i | input | 1 | Zero flag |
| done_o | output | 1 | One-cycle pulse: results are valid |
| taken_o | output | 1 | Branch taken |
| unsupported_o | output | 1 | External-condition branch, not resolved |
| next_pc_o | output | 16 | Program counter after the instruction |
| cycles_o | output | 4 | Cycles consumed by the instruction (7 or 9) |

## Verification
The assertions check on every cycle the handshake timing of the done pulse and the agreement between the taken bit and the reported cost. They also check that an unsupported branch is never taken, that a not-taken result keeps the presented program counter, and that results hold while no start arrives. Only the bench scenarios can show that each of the sixteen condition codes produces the right answer for every flag combination. The same applies to the target arithmetic in both directions, including wraparound at the ends of the address space. The bench sweeps all 512 combinations of code, flags and direction, adds directed wraparound cases, and runs a seeded random mix.

// File: rtl/brcond_pkg.sv
package brcond_pkg;

    // Opcode field positions decoded by this unit
    localparam int COND_LSB = 0;
    localparam int COND_W   = 4;
    localparam int COND_MSB = COND_LSB + COND_W - 1;
    localparam int EXT_BIT  = 4;
    localparam int DIR_BIT  = 5;

    typedef struct packed {
        logic c;
        logic o;
        logic s;
        logic z;
    } flags_t;

endpackage

// File: rtl/brcond_eval.sv
module brcond_eval
    import brcond_pkg::*;
(
    input  logic [COND_W-1:0] code_i,
    input  flags_t            flags_i,
    output logic              hit_o
);
    localparam int SEL_W = COND_W - 1;

    logic base;
    logic sov;

    always_comb begin
        sov = flags_i.s ^ flags_i.o;
        unique case (code_i[SEL_W-1:0])
            3'd0:    base = 1'b1;
            3'd1:    base = flags_i.c;
            3'd2:    base = flags_i.o;
            3'd3:    base = ~flags_i.s;
            3'd4:    base = flags_i.z;
            3'd5:    base = sov;
            3'd6:    base = flags_i.z | sov;
            default: base = flags_i.c ^ flags_i.s;
        endcase
        // upper half of the code space negates the lower half (R3, R4)
        hit_o = base ^ code_i[COND_W-1];
    end

endmodule

// File: rtl/brcond_target.sv
module brcond_target #(
    parameter int WORD_W = 16
) (
    input  logic              back_i,
    input  logic [WORD_W-1:0] offset_i,
    input  logic [WORD_W-1:0] pc_i,
    output logic [WORD_W-1:0] target_o
);
    logic [WORD_W-1:0] addend;

    always_comb begin
        // complement equals negate-minus-one, so no incrementer is needed (R6)
        addend   = offset_i ^ {WORD_W{back_i}};
        target_o = pc_i + addend;
    end

endmodule

// File: rtl/brcond_cost.sv
module brcond_cost #(
    parameter int TAKEN_CYC     = 9,
    parameter int NOT_TAKEN_CYC = 7,
    parameter int CYC_W         = 4
) (
    input  logic             taken_i,
    output logic [CYC_W-1:0] cycles_o
);
    localparam logic [CYC_W-1:0] COST_T = CYC_W'(TAKEN_CYC);
    localparam logic [CYC_W-1:0] COST_N = CYC_W'(NOT_TAKEN_CYC);

    always_comb cycles_o = taken_i ? COST_T : COST_N;

endmodule

// File: rtl/brcond_unit.sv
module brcond_unit
    import brcond_pkg::*;
#(
    parameter int WORD_W        = 16,
    parameter int OP_W          = 10,
    parameter int TAKEN_CYC     = 9,
    parameter int NOT_TAKEN_CYC = 7,
    parameter int CYC_W         = $clog2(TAKEN_CYC + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [OP_W-1:0]   opcode_i,
    input  logic [WORD_W-1:0] offset_i,
    input  logic [WORD_W-1:0] pc_i,
    input  logic              flag_c_i,
    input  logic              flag_o_i,
    input  logic              flag_s_i,
    input  logic              flag_z_i,
    output logic              done_o,
    output logic              taken_o,
    output logic              unsupported_o,
    output logic [WORD_W-1:0] next_pc_o,
    output logic [CYC_W-1:0]  cycles_o
);
    typedef struct packed {
        logic              done;
        logic              taken;
        logic              unsup;
        logic [WORD_W-1:0] next_pc;
        logic [CYC_W-1:0]  cycles;
    } res_t;

    res_t st_d, st_q;

    flags_t            flags;
    logic [COND_W-1:0] code;
    logic              ext, back, hit, take;
    logic [WORD_W-1:0] target;
    logic [CYC_W-1:0]  cost;

    always_comb begin
        flags = '{c: flag_c_i, o: flag_o_i, s: flag_s_i, z: flag_z_i};
        code  = opcode_i[COND_MSB:COND_LSB];
        ext   = opcode_i[EXT_BIT];
        back  = opcode_i[DIR_BIT];
    end

    brcond_eval u_eval (
        .code_i  (code),
        .flags_i (flags),
        .hit_o   (hit)
    );

    // external-condition branches never redirect (R9)
    always_comb take = hit & ~ext;

    brcond_target #(.WORD_W(WORD_W)) u_target (
        .back_i   (back),
        .offset_i (offset_i),
        .pc_i     (pc_i),
        .target_o (target)
    );

    brcond_cost #(
        .TAKEN_CYC     (TAKEN_CYC),
        .NOT_TAKEN_CYC (NOT_TAKEN_CYC),
        .CYC_W         (CYC_W)
    ) u_cost (
        .taken_i  (take),
        .cycles_o (cost)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (start_i) begin
            st_d.done    = 1'b1;
            st_d.taken   = take;
            st_d.unsup   = ext;
            st_d.next_pc = take ? target : pc_i;
            st_d.cycles  = cost;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        done_o        = st_q.done;
        taken_o       = st_q.taken;
        unsupported_o = st_q.unsup;
        next_pc_o     = st_q.next_pc;
        cycles_o      = st_q.cycles;
    end

    assert_done_follows_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> done_o);

    assert_done_needs_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(start_i));

    assert_cost_taken_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && taken_o) |-> (cycles_o == CYC_W'(TAKEN_CYC)));

    assert_cost_not_taken_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !taken_o) |-> (cycles_o == CYC_W'(NOT_TAKEN_CYC)));

    assert_unsup_not_taken_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && unsupported_o) |-> !taken_o);

    assert_unsup_from_opcode_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (unsupported_o == $past(opcode_i[EXT_BIT])));

    assert_keep_pc_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !taken_o) |-> (next_pc_o == $past(pc_i)));

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> ($stable(next_pc_o) && $stable(taken_o)
                      && $stable(unsupported_o) && $stable(cycles_o)));

endmodule

// File: tb/tb_brcond_unit.sv
module tb_brcond_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [9:0]  opcode_i = '0;
    logic [15:0] offset_i = '0;
    logic [15:0] pc_i = '0;
    logic        flag_c_i = 1'b0, flag_o_i = 1'b0, flag_s_i = 1'b0, flag_z_i = 1'b0;
    logic        done_o, taken_o, unsupported_o;
    logic [15:0] next_pc_o;
    logic [3:0]  cycles_o;

    int n_checks = 0;
    int n_fail   = 0;
    int seed_tmp;

    always #4 clk = ~clk;   // 125 MHz

    brcond_unit dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .opcode_i(opcode_i),
        .offset_i(offset_i), .pc_i(pc_i),
        .flag_c_i(flag_c_i), .flag_o_i(flag_o_i), .flag_s_i(flag_s_i), .flag_z_i(flag_z_i),
        .done_o(done_o), .taken_o(taken_o), .unsupported_o(unsupported_o),
        .next_pc_o(next_pc_o), .cycles_o(cycles_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // truth table written from R3/R4; f = {c,o,s,z}
    function automatic logic ref_cond(input logic [3:0] code, input logic [3:0] f);
        logic c, o, s, z;
        {c, o, s, z} = f;
        case (code)
            4'd0:  return 1'b1;
            4'd1:  return c;
            4'd2:  return o;
            4'd3:  return !s;
            4'd4:  return z;
            4'd5:  return s != o;
            4'd6:  return z || (s != o);
            4'd7:  return c != s;
            4'd8:  return 1'b0;
            4'd9:  return !c;
            4'd10: return !o;
            4'd11: return s;
            4'd12: return !z;
            4'd13: return s == o;
            4'd14: return !z && (s == o);
            default: return c == s;
        endcase
    endfunction

    task automatic run_op(input logic [3:0] code, input logic ext, input logic back,
                          input logic [15:0] off, input logic [15:0] pc,
                          input logic [3:0] f, input bit check_hold);
        logic        exp_taken;
        logic [15:0] exp_pc;
        logic [15:0] held_pc;
        string       ctag;
        @(negedge clk);
        opcode_i = 10'h200 | ({9'd0, back} << 5) | ({9'd0, ext} << 4) | {6'd0, code};
        offset_i = off;
        pc_i     = pc;
        {flag_c_i, flag_o_i, flag_s_i, flag_z_i} = f;
        start_i  = 1'b1;
        @(negedge clk);
        start_i  = 1'b0;
        exp_taken = !ext && ref_cond(code, f);
        if (!exp_taken)  exp_pc = pc;
        else if (back)   exp_pc = pc - off - 16'd1;
        else             exp_pc = pc + off;
        ctag = (code < 4'd8) ? "R3" : "R4";
        if (ext) ctag = "R9";
        chk("R2 done pulse", done_o, 1);
        chk(ctag, taken_o, exp_taken);
        chk("R9 unsupported", unsupported_o, ext);
        chk(!exp_taken ? "R7 keep pc" : (back ? "R6 backward target" : "R5 forward target"),
            next_pc_o, exp_pc);
        chk("R8 cycles", cycles_o, exp_taken ? 9 : 7);
        if (check_hold) begin
            held_pc = next_pc_o;
            pc_i = ~pc; offset_i = ~off; opcode_i = ~opcode_i;
            @(negedge clk);
            chk("R2 done low", done_o, 0);
            chk("R10 hold pc", next_pc_o, held_pc);
            chk("R10 hold taken", taken_o, exp_taken);
            chk("R10 hold cycles", cycles_o, exp_taken ? 9 : 7);
        end
    endtask

    initial begin
        seed_tmp = $urandom(32'h5EED_B12C);
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 done", done_o, 0);
        chk("R1 taken", taken_o, 0);
        chk("R1 unsupported", unsupported_o, 0);
        chk("R1 next_pc", next_pc_o, 0);
        chk("R1 cycles", cycles_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", {done_o, taken_o, next_pc_o}, 0);

        // exhaustive: every code, every flag set, both directions (R3 R4 R5 R6 R7 R8)
        for (int d = 0; d < 2; d++)
            for (int cd = 0; cd < 16; cd++)
                for (int fl = 0; fl < 16; fl++)
                    run_op(cd[3:0], 1'b0, d[0], 16'h0123 + 16'(cd), 16'h4000 + 16'(fl),
                           fl[3:0], (fl == 5));

        // directed wrap corners
        run_op(4'd0, 1'b0, 1'b0, 16'h0001, 16'hFFFF, 4'h0, 1'b1); // R5 wraps to 0
        run_op(4'd0, 1'b0, 1'b1, 16'h0000, 16'h1000, 4'h0, 1'b0); // R6 pc-1
        run_op(4'd0, 1'b0, 1'b1, 16'h0000, 16'h0000, 4'h0, 1'b0); // R6 wraps to FFFF
        run_op(4'd0, 1'b0, 1'b1, 16'hFFFF, 16'h0005, 4'h0, 1'b0); // R6 offset all ones
        run_op(4'd8, 1'b0, 1'b0, 16'h0010, 16'h2000, 4'hF, 1'b1); // R4 never taken

        // R9: external-condition branches for all codes and flags
        for (int cd = 0; cd < 16; cd++)
            run_op(cd[3:0], 1'b1, cd[0], 16'h0040, 16'h3000, cd[3:0] ^ 4'h6, (cd == 0));

        // seeded random mix
        for (int i = 0; i < 300; i++) begin
            logic [31:0] r;
            r = $urandom;
            run_op(r[3:0], (r[7:4] == 4'h0), r[8], 16'($urandom), 16'($urandom),
                   r[12:9], r[13]);
        end

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule